// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block runs whole page operations on an 8-bit raw NAND device. It accepts one request at a time: a start strobe, an operation code, a page number and a byte count. For that request it emits the command and address latch cycles in order, moves page data between the device and a page buffer port, and reports the outcome. Each operation code selects one of three fixed sequences: page read, page program with a status check at the end, and an initialisation status read that sets a write-protected flag.

Every command, address or data step drives one strobe for a configurable number of cycles. After each step the block samples the device ready line on every cycle, up to a configurable number of samples. If the line stays low for all of those samples, the sequence ends as a timeout failure. A request with an odd byte count cannot be split into 16-bit halfwords, so it is refused at once and the device sees no activity. Outside logic keeps the buffer: the block gives it an address, a write enable and write data, and reads back one byte through a separate read-data input.

Top module: `nand_page_seq`

## Requirements
- R1: A read or program sends five address bytes, each latched with `nf_ale` high: zero, zero, then `page[7:0]`, `page[15:8]` and `page[23:16]`.
- R2: A read (`op`=0) sends command 0x00, the five address bytes and command 0x30. It then waits for ready and performs `len` data-out strobes, writing byte i to buffer address i for i from 0 to `len`-1.
- R3: A program (`op`=1) sends command 0x80, the five address bytes, and `len` data bytes read from buffer addresses 0 upward. It then sends command 0x10, waits for ready, sends command 0x70 and reads one status byte. `fail` is set equal to bit 0 of that byte.
- R4: An initialisation (`op`=2) sends command 0x70 and one address byte of 0x00, then reads a status byte. `wp` becomes 1 when bit 7 of that byte is 0 and 0 when it is 1. No other operation changes `wp`.
- R5: A command strobe drives `nf_cle` high and an address strobe drives `nf_ale` high. The two are never high together. `nf_we_n` and `nf_re_n` are never low together. Every write strobe stays low for exactly `STROBE_CYC` cycles.
- R6: After each step, `nf_rb` is sampled once per cycle for at most `POLL_LIMIT` samples. If all of them are low, the sequence ends with `fail`=1 and no further strobes. A high sample at or before sample `POLL_LIMIT` lets the sequence continue.
- R7: The request is refused when `op` is 3, or when a read or program has an odd `len`. For a refused request, `done` and `fail` are both 1 in the cycle after the start, `busy` stays 0, and no strobe occurs.
- R8: `start` has no effect while `busy` is 1.
- R9: `done` is high for one cycle at the end of every accepted or refused request, and `busy` is 0 in that cycle. A start in that same cycle is accepted. Starting a request clears `fail`. After reset, `busy`, `done`, `fail` and `wp` are all 0.
- R10: With `len` of 0, a read ends after the ready wait that follows 0x30, and a program goes straight from the last address byte to 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken while idle |
| op | input | 2 | 0 read, 1 program, 2 initialisation status, 3 invalid |
| page | input | PAGE_W | Page number |
| len | input | LEN_W | Data byte count, must be even |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| fail | output | 1 | Refusal, timeout or program failure |
| wp | output | 1 | Device reported write protection |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven to the device |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_out` |
| nf_dq_in | input | 8 | Byte from the device |
| nf_rb | input | 1 | Device ready (high) or busy (low) |
| buf_addr | output | LEN_W | Page buffer byte address |
| buf_we | output | 1 | Page buffer write enable |
| buf_wdata | output | 8 | Byte written into the page buffer |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` |

## Verification
The end of one request and the acceptance of the next can fall in the same cycle: `done` goes high on the edge that returns the sequencer to idle, so a `start` held during that pulse is taken at once. The bench ends a program whose status byte reports failure, raises `start` for an initialisation in the very cycle `done` is high, and then expects `busy` high with `fail` already cleared one cycle later. It also expects the follow-on initialisation to produce exactly its two latch cycles. A start raised during a read checks the opposite case: the bench expects the read's command log to be complete and no second `done`.

// File: rtl/nps_pkg.sv
package nps_pkg;
   typedef enum logic [1:0] {
      OP_READ = 2'd0,
      OP_PROG = 2'd1,
      OP_INIT = 2'd2,
      OP_BAD  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      K_CMD,
      K_ADR,
      K_WR,
      K_RD,
      K_STAT
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_DRIVE,
      S_POLL
   } st_e;

   localparam logic [7:0] CMD_RD_SETUP = 8'h00;
   localparam logic [7:0] CMD_RD_GO    = 8'h30;
   localparam logic [7:0] CMD_SERIN    = 8'h80;
   localparam logic [7:0] CMD_PRG_GO   = 8'h10;
   localparam logic [7:0] CMD_STATUS   = 8'h70;
   localparam int         COL_CYCLES   = 2;
endpackage

// File: rtl/nps_pace.sv
// Phase timer: measures the strobe width and bounds the ready poll.
module nps_pace #(
   parameter int STROBE_CYC = 2,
   parameter int POLL_LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_drive,
   input  logic in_poll,
   input  logic rb,
   output logic strobe_last,
   output logic poll_expired
);
   localparam int SPAN = (STROBE_CYC > POLL_LIMIT) ? STROBE_CYC : POLL_LIMIT;
   localparam int CW   = $clog2(SPAN + 1);

   logic [CW-1:0] cnt;
   logic          restart;

   generate
      if (STROBE_CYC == 1) begin : g_single
         assign strobe_last = in_drive;
      end else begin : g_multi
         assign strobe_last = in_drive && (cnt == CW'(STROBE_CYC - 1));
      end
   endgenerate

   assign poll_expired = in_poll && !rb && (cnt == CW'(POLL_LIMIT - 1));
   assign restart      = !(in_drive || in_poll) || strobe_last || (in_poll && rb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else              cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/nps_addr_mux.sv
// Selects the byte for each address cycle: column bytes are zero, row bytes come from the page.
module nps_addr_mux
   import nps_pkg::*;
#(
   parameter int PAGE_W = 24,
   parameter int AIW    = 3
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [AIW-1:0]    idx,
   output logic [7:0]        abyte
);
   localparam int ROW_BYTES = (PAGE_W + 7) / 8;

   logic [ROW_BYTES*8-1:0] page_ext;
   assign page_ext = (ROW_BYTES*8)'(page);

   always_comb begin
      abyte = 8'h00;
      for (int i = 0; i < ROW_BYTES; i++) begin
         if (idx == AIW'(COL_CYCLES + i)) abyte = page_ext[i*8 +: 8];
      end
   end
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
   import nps_pkg::*;
#(
   parameter int PAGE_W     = 24,
   parameter int LEN_W      = 12,
   parameter int STROBE_CYC = 2,
   parameter int POLL_LIMIT = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [PAGE_W-1:0] page,
   input  logic [LEN_W-1:0]  len,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              wp,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [7:0]        nf_dq_out,
   output logic              nf_dq_oe,
   input  logic [7:0]        nf_dq_in,
   input  logic              nf_rb,
   output logic [LEN_W-1:0]  buf_addr,
   output logic              buf_we,
   output logic [7:0]        buf_wdata,
   input  logic [7:0]        buf_rdata
);
   localparam int ROW_BYTES = (PAGE_W + 7) / 8;
   localparam int ADR_N     = COL_CYCLES + ROW_BYTES;
   localparam int AIW       = $clog2(ADR_N);

   generate
      if (STROBE_CYC < 1 || POLL_LIMIT < 2 || LEN_W < 2 || PAGE_W < 1 || PAGE_W > 32) begin : g_bad_cfg
         $error("nand_page_seq: parameter out of range");
      end
   endgenerate

   st_e               state;
   kind_e             step, n_step;
   op_e               op_q;
   logic [7:0]        cmd_q, n_cmd, abyte;
   logic [PAGE_W-1:0] page_q;
   logic [LEN_W-1:0]  len_q, dat_cnt;
   logic [AIW-1:0]    adr_cnt;
   logic              n_fin, reject, strobe_last, poll_expired, drv;
   logic [7:0]        first_cmd;

   nps_pace #(.STROBE_CYC(STROBE_CYC), .POLL_LIMIT(POLL_LIMIT)) u_pace (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_drive     (state == S_DRIVE),
      .in_poll      (state == S_POLL),
      .rb           (nf_rb),
      .strobe_last  (strobe_last),
      .poll_expired (poll_expired)
   );

   nps_addr_mux #(.PAGE_W(PAGE_W), .AIW(AIW)) u_amux (
      .page  (page_q),
      .idx   (adr_cnt),
      .abyte (abyte)
   );

   assign reject    = (op == OP_BAD) || ((op == OP_READ || op == OP_PROG) && len[0]);
   assign first_cmd = (op == OP_READ) ? CMD_RD_SETUP : (op == OP_PROG) ? CMD_SERIN : CMD_STATUS;

   // Step that follows the current one once the device reports ready.
   always_comb begin
      n_step = step;
      n_cmd  = cmd_q;
      n_fin  = 1'b0;
      case (step)
         K_CMD: begin
            case (cmd_q)
               CMD_RD_SETUP, CMD_SERIN: n_step = K_ADR;
               CMD_RD_GO: begin
                  if (len_q == '0) n_fin = 1'b1;
                  else             n_step = K_RD;
               end
               CMD_PRG_GO: n_cmd = CMD_STATUS;
               default: n_step = (op_q == OP_INIT) ? K_ADR : K_STAT;
            endcase
         end
         K_ADR: begin
            if (op_q == OP_INIT) begin
               n_step = K_STAT;
            end else if (adr_cnt == AIW'(ADR_N - 1)) begin
               if (op_q == OP_READ) begin
                  n_step = K_CMD;
                  n_cmd  = CMD_RD_GO;
               end else if (len_q == '0) begin
                  n_step = K_CMD;
                  n_cmd  = CMD_PRG_GO;
               end else begin
                  n_step = K_WR;
               end
            end
         end
         K_WR: begin
            if (dat_cnt == len_q - LEN_W'(1)) begin
               n_step = K_CMD;
               n_cmd  = CMD_PRG_GO;
            end
         end
         K_RD:    n_fin = (dat_cnt == len_q - LEN_W'(1));
         default: n_fin = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         step    <= K_CMD;
         cmd_q   <= 8'h00;
         op_q    <= OP_READ;
         page_q  <= '0;
         len_q   <= '0;
         adr_cnt <= '0;
         dat_cnt <= '0;
         done    <= 1'b0;
         fail    <= 1'b0;
         wp      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  op_q    <= op_e'(op);
                  page_q  <= page;
                  len_q   <= len;
                  adr_cnt <= '0;
                  dat_cnt <= '0;
                  if (reject) begin
                     fail <= 1'b1;
                     done <= 1'b1;
                  end else begin
                     fail  <= 1'b0;
                     state <= S_DRIVE;
                     step  <= K_CMD;
                     cmd_q <= first_cmd;
                  end
               end
            end
            S_DRIVE: begin
               if (strobe_last) begin
                  state <= S_POLL;
                  if (step == K_STAT) begin
                     if (op_q == OP_INIT) wp   <= ~nf_dq_in[7];
                     else                 fail <= nf_dq_in[0];
                  end
               end
            end
            S_POLL: begin
               if (nf_rb) begin
                  if (n_fin) begin
                     state <= S_IDLE;
                     done  <= 1'b1;
                  end else begin
                     state <= S_DRIVE;
                     step  <= n_step;
                     cmd_q <= n_cmd;
                     if (step == K_ADR)                   adr_cnt <= adr_cnt + AIW'(1);
                     if (step == K_WR || step == K_RD)    dat_cnt <= dat_cnt + LEN_W'(1);
                  end
               end else if (poll_expired) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
                  fail  <= 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign drv       = (state == S_DRIVE);
   assign busy      = (state != S_IDLE);
   assign nf_cle    = drv && (step == K_CMD);
   assign nf_ale    = drv && (step == K_ADR);
   assign nf_we_n   = !(drv && (step == K_CMD || step == K_ADR || step == K_WR));
   assign nf_re_n   = !(drv && (step == K_RD || step == K_STAT));
   assign nf_dq_oe  = !nf_we_n;
   assign nf_dq_out = (step == K_CMD) ? cmd_q : (step == K_ADR) ? abyte : buf_rdata;
   assign buf_addr  = dat_cnt;
   assign buf_we    = drv && (step == K_RD) && strobe_last;
   assign buf_wdata = nf_dq_in;

   // R5: command and address latches are exclusive
   a_r5_latch_excl: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale));
   // R5: read and write strobes never overlap
   a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) nf_we_n || nf_re_n);
   // R5: the block never drives the bus while the device drives it
   a_r5_bus_turn: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_dq_oe);
   // R7: refused request ends at once with no strobe
   a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && reject) |=> (done && fail && !busy && nf_we_n && nf_re_n));
   // R6: an exhausted poll window ends the sequence as a failure
   a_r6_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_POLL && poll_expired) |=> (done && fail && !busy));
   // R9: done only in idle, only after work or a start
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
   a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) || $past(start)));
endmodule

// File: tb/tb_nand_page_seq.sv
module tb_nand_page_seq;
   localparam int SC = 2;
   localparam int PL = 12;
   localparam int LW = 6;
   localparam int PW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          start = 1'b0;
   logic [1:0]    op_i = 2'd0;
   logic [PW-1:0] page_i = '0;
   logic [LW-1:0] len_i = '0;
   logic          busy, done, fail, wp, cle, ale, we_n, re_n, dq_oe, buf_we;
   logic          rb = 1'b1;
   logic [7:0]    dq_out, dq_in, buf_wdata, buf_rdata;
   logic [LW-1:0] buf_addr;

   int checks = 0;
   int errors = 0;

   logic [7:0] wmem [0:63];
   logic [7:0] rmem [0:63];
   logic [7:0] ev_b [0:1023];
   int         ev_k [0:1023];
   int         ev_w [0:1023];
   int         ev_n = 0;
   int         pend_k = 0;
   logic [7:0] pend_b = 8'h00;
   int         low_len = 0;
   logic       prev_we = 1'b1;
   logic       prev_re = 1'b1;
   logic [7:0] last_cmd = 8'h00;
   int         rd_idx = 0;
   int         busy_cnt = 0;
   int         re_act = 0;
   int         bad_bus = 0;
   int         busy_len = 3;
   logic [7:0] stat_byte = 8'h80;
   logic [7:0] seed = 8'h00;

   function automatic logic [7:0] pat(input int i, input logic [7:0] s);
      return 8'(i * 37) + s;
   endfunction

   assign dq_in     = (last_cmd == 8'h70) ? stat_byte : pat(rd_idx, seed);
   assign buf_rdata = wmem[buf_addr];

   nand_page_seq #(.PAGE_W(PW), .LEN_W(LW), .STROBE_CYC(SC), .POLL_LIMIT(PL)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .page(page_i), .len(len_i),
      .busy(busy), .done(done), .fail(fail), .wp(wp),
      .nf_cle(cle), .nf_ale(ale), .nf_we_n(we_n), .nf_re_n(re_n),
      .nf_dq_out(dq_out), .nf_dq_oe(dq_oe), .nf_dq_in(dq_in), .nf_rb(rb),
      .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
   );

   // Device model: logs latched bytes on the rising write strobe, serves read data.
   always @(negedge clk) begin
      if (buf_we) rmem[buf_addr] = buf_wdata;
      if (busy_cnt > 0) begin
         busy_cnt = busy_cnt - 1;
         if (busy_cnt == 0) rb = 1'b1;
      end
      if ((cle && ale) || (!we_n && !re_n)) bad_bus = bad_bus + 1;
      if (!re_n) re_act = re_act + 1;
      if (!we_n) begin
         low_len = low_len + 1;
         pend_b  = dq_out;
         pend_k  = cle ? 0 : (ale ? 1 : 2);
      end else if (!prev_we) begin
         if (ev_n < 1024) begin
            ev_b[ev_n] = pend_b;
            ev_k[ev_n] = pend_k;
            ev_w[ev_n] = low_len;
            ev_n = ev_n + 1;
         end
         low_len = 0;
         if (pend_k == 0) begin
            last_cmd = pend_b;
            rd_idx   = 0;
            if ((pend_b == 8'h30 || pend_b == 8'h10) && busy_len > 0) begin
               rb       = 1'b0;
               busy_cnt = busy_len;
            end
         end
      end
      if (re_n && !prev_re && last_cmd != 8'h70) rd_idx = rd_idx + 1;
      prev_we = we_n;
      prev_re = re_n;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic launch(input logic [1:0] o, input logic [PW-1:0] p, input int l);
      start = 1'b1; op_i = o; page_i = p; len_i = LW'(l);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic run(input logic [1:0] o, input logic [PW-1:0] p, input int l, output int base);
      @(negedge clk);
      base = ev_n;
      launch(o, p, l);
      wait_done();
   endtask

   task automatic chk_addr(input int b, input logic [PW-1:0] p, input string req);
      for (int i = 0; i < 5; i++) begin
         logic [7:0] e;
         e = (i < 2) ? 8'h00 : 8'(p >> (8 * (i - 2)));
         chk(ev_k[b+i] == 1 && ev_b[b+i] == e, req, int'(ev_b[b+i]), int'(e));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int b;
      int acts;
      for (int i = 0; i < 64; i++) wmem[i] = pat(i, 8'h5A);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fail && !wp, "R9 reset flags", int'({busy, done, fail, wp}), 0);
      chk(we_n && re_n && !cle && !ale && !dq_oe, "R5 reset pins", int'({we_n, re_n, cle, ale}), 12);

      // R4 initialisation, device not protected then protected
      stat_byte = 8'h80;
      run(2'd2, 24'h123456, 0, b);
      chk(ev_n - b == 2, "R4 init latch count", ev_n - b, 2);
      chk(ev_k[b] == 0 && ev_b[b] == 8'h70, "R4 status command", int'(ev_b[b]), 8'h70);
      chk(ev_k[b+1] == 1 && ev_b[b+1] == 8'h00, "R4 zero address", int'(ev_b[b+1]), 0);
      chk(!wp && !fail, "R4 wp clear", int'(wp), 0);
      @(negedge clk);
      chk(!done, "R9 done lasts one cycle", int'(done), 0);
      stat_byte = 8'h00;
      run(2'd2, 24'h000000, 0, b);
      chk(wp, "R4 wp set", int'(wp), 1);

      // R1 R2 R10 read sweep over pages and lengths
      for (int pi = 0; pi < 3; pi++) begin
         for (int li = 0; li < 4; li++) begin
            logic [PW-1:0] pg;
            int ln;
            pg   = (pi == 0) ? 24'h000000 : (pi == 1) ? 24'hA5C3E1 : 24'hFFFFFF;
            ln   = li * 6;
            seed = 8'(pi * 16 + li + 1);
            run(2'd0, pg, ln, b);
            chk(ev_n - b == 7, "R2 read latch count", ev_n - b, 7);
            chk(ev_k[b] == 0 && ev_b[b] == 8'h00, "R2 read setup", int'(ev_b[b]), 0);
            chk_addr(b + 1, pg, "R1 read address bytes");
            chk(ev_k[b+6] == 0 && ev_b[b+6] == 8'h30, "R2 read confirm", int'(ev_b[b+6]), 8'h30);
            for (int i = 0; i < ln; i++)
               chk(rmem[i] == pat(i, seed), "R2 read data", int'(rmem[i]), int'(pat(i, seed)));
            chk(!fail, "R2 read ok", int'(fail), 0);
            chk(wp, "R4 wp untouched by read", int'(wp), 1);
            if (ln == 0) begin
               @(negedge clk);
               chk(!busy && !done, "R10 read zero length ends", int'(busy), 0);
            end
         end
      end

      // R1 R3 R10 program sweep with passing and failing status
      for (int k = 0; k < 4; k++) begin
         logic [PW-1:0] pg;
         int ln;
         pg        = PW'(24'h010203 * (k + 1));
         ln        = k * 4;
         stat_byte = (k % 2 == 1) ? 8'hC1 : 8'hC0;
         run(2'd1, pg, ln, b);
         chk(ev_n - b == ln + 8, "R3 program latch count", ev_n - b, ln + 8);
         chk(ev_k[b] == 0 && ev_b[b] == 8'h80, "R3 serial input command", int'(ev_b[b]), 8'h80);
         chk_addr(b + 1, pg, "R1 program address bytes");
         for (int i = 0; i < ln; i++)
            chk(ev_k[b+6+i] == 2 && ev_b[b+6+i] == wmem[i], "R3 program data",
                int'(ev_b[b+6+i]), int'(wmem[i]));
         chk(ev_k[b+6+ln] == 0 && ev_b[b+6+ln] == 8'h10, "R3 program confirm",
             int'(ev_b[b+6+ln]), 8'h10);
         chk(ev_k[b+7+ln] == 0 && ev_b[b+7+ln] == 8'h70, "R3 status after program",
             int'(ev_b[b+7+ln]), 8'h70);
         chk(fail == (k % 2 == 1), "R3 fail from status bit 0", int'(fail), k % 2);
         chk(wp, "R4 wp untouched by program", int'(wp), 1);
         if (ln == 0)
            chk(ev_b[b+6] == 8'h10, "R10 program zero length goes to confirm", int'(ev_b[b+6]), 8'h10);
      end

      // R7 refused requests
      stat_byte = 8'h80;
      for (int k = 0; k < 3; k++) begin
         acts = re_act;
         @(negedge clk);
         b = ev_n;
         launch((k == 2) ? 2'd3 : 2'(k), 24'h777777, (k == 2) ? 4 : 5);
         chk(done && fail && !busy, "R7 refusal reported next cycle", int'({done, fail, busy}), 6);
         @(negedge clk);
         chk(!done && !busy, "R7 refusal single done", int'({done, busy}), 0);
         chk(ev_n == b && re_act == acts, "R7 no device activity", ev_n - b, 0);
      end

      // R6 ready arrives on the last allowed sample, then never in time
      busy_len = PL - 1;
      seed = 8'h33;
      run(2'd0, 24'h000042, 4, b);
      chk(!fail, "R6 ready on last sample", int'(fail), 0);
      for (int i = 0; i < 4; i++)
         chk(rmem[i] == pat(i, seed), "R6 data after long wait", int'(rmem[i]), int'(pat(i, seed)));
      busy_len = PL;
      seed = 8'h34;
      acts = re_act;
      run(2'd0, 24'h000043, 4, b);
      chk(fail, "R6 timeout fails", int'(fail), 1);
      chk(ev_n - b == 7, "R6 no latch after timeout", ev_n - b, 7);
      chk(re_act == acts, "R6 no data strobe after timeout", re_act - acts, 0);
      busy_len = 3;

      // R8 start while busy is ignored
      seed = 8'h44;
      @(negedge clk);
      b = ev_n;
      launch(2'd0, 24'h0A0B0C, 8);
      repeat (4) @(negedge clk);
      start = 1'b1; op_i = 2'd1; len_i = LW'(2);
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(ev_n - b == 7, "R8 no extra latch cycles", ev_n - b, 7);
      for (int i = 0; i < 8; i++)
         chk(rmem[i] == pat(i, seed), "R8 read intact", int'(rmem[i]), int'(pat(i, seed)));
      @(negedge clk);
      chk(!busy && !done, "R8 no second sequence", int'({busy, done}), 0);

      // R9 start raised in the done cycle of a failing program
      stat_byte = 8'hC1;
      run(2'd1, 24'h000001, 2, b);
      chk(fail && done, "R9 program ends failing", int'(fail), 1);
      stat_byte = 8'h80;
      b = ev_n;
      launch(2'd2, 24'h000000, 0);
      chk(busy && !fail, "R9 start in done cycle taken and fail cleared", int'({busy, fail}), 2);
      wait_done();
      chk(ev_n - b == 2 && !wp, "R9 follow-on init", ev_n - b, 2);

      // R5 strobe width and pin exclusivity over the whole run
      begin
         int nbad;
         nbad = 0;
         for (int i = 0; i < ev_n; i++) if (ev_w[i] != SC) nbad = nbad + 1;
         chk(nbad == 0, "R5 write strobe width", nbad, 0);
         chk(bad_bus == 0, "R5 latch and strobe exclusivity", bad_bus, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule